// File: doc/BRIEF.md
# Low-Power Mode Sequencer

This controller moves a processor subsystem out of its run state into one of three low-power states and back again. Software first programs a mode selector, a 32-line wake-select mask and a qualification count through a small write port. The core then issues a one-cycle entry pulse. The sequencer gates the oscillator/PLL enable, the core clock enable and the system clock output enable to suit the chosen state. It then watches the allowed wake sources for that state and sends a one-cycle wake pulse back to the core when it returns to run.

The block runs on an always-on reference clock. In standby, wake-up from a GPIO line needs a low level that is held long enough, and shorter glitches are filtered out. Halt is refused unless the watchdog clock is running. After a halt wake, the oscillator gets a fixed settle period before the core clock comes back. A pin-hold stage keeps the output pin values frozen for as long as the core is away.

Top module: `lpm_sequencer`

## Requirements
- R1: While reset is low and after it is released, the block is in run with `osc_pll_en`, `core_clk_en` and `sysout_en` high and `wake_o` low. The mode selector, wake mask and qualification count all reset to zero.
- R2: Writes use `cfg_addr` 0 for the mode selector (data bits 1:0), 1 for the wake mask (bits 31:0) and 2 for the qualification count (bits 5:0). Mode 00 selects idle, mode 01 selects standby, and 10 or 11 selects halt.
- R3: In idle all three enables stay high. The block returns to run at the first edge that samples `wd_int_n` low or `irq_pend` high.
- R4: In standby `osc_pll_en` is high and `core_clk_en` and `sysout_en` are low. The block returns to run at the first edge that samples `wd_int_n` low or `dbg_req` high, or when the GPIO qualification of R5 completes.
- R5: In standby, a GPIO wake needs at least one line that is enabled in the mask and low on qualification count + 2 consecutive edges. A shorter low pulse, or a low level on an unmasked line, leaves the block in standby.
- R6: In halt all three enables are low. An edge that samples any masked GPIO line low, `dbg_req` high or `wd_int_n` low starts the wake sequence. `irq_pend` has no effect in halt.
- R7: A halt request made while `wdclk_active` is low is refused. The block stays in run with all enables high.
- R8: After a halt wake, `osc_pll_en` is high and the core and system clock enables stay low for exactly 16 cycles. The block then returns to run.
- R9: Every return to run raises `wake_o` for exactly one cycle. That cycle is the first run cycle.
- R10: `idle_req` pulses that arrive while the block is in any low-power or settle state are ignored.
- R11: In run `pin_o` follows `pin_i`. In every other state `pin_o` holds the `pin_i` value sampled on the edge that accepted the entry request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Configuration register select |
| cfg_wdata | input | 32 | Configuration write data |
| idle_req | input | 1 | One-cycle low-power entry request from the core |
| wdclk_active | input | 1 | High while the watchdog clock runs |
| wd_int_n | input | 1 | Active-low watchdog wake |
| irq_pend | input | 1 | Any enabled interrupt pending |
| dbg_req | input | 1 | Debugger wake request |
| gpio_n | input | 32 | Active-low GPIO wake lines |
| pin_i | input | 8 | Output pin values driven by the core |
| pin_o | output | 8 | Output pin values seen by the pads |
| osc_pll_en | output | 1 | Oscillator and PLL enable |
| core_clk_en | output | 1 | Core clock enable |
| sysout_en | output | 1 | System clock output enable |
| wake_o | output | 1 | One-cycle wake pulse to the core |

## Verification
Each low-power state is entered and then hit with every source on its wake list, plus one source that is not on the list. This separates correct per-mode gating of wake sources from a single shared wake OR. In standby the GPIO low pulses are one cycle short of the qualification window, exactly as long as it, and placed on an unmasked line. These three cases separate an off-by-one in the down-counter from missing mask gating. Halt is attempted with the watchdog clock both stopped and running, and with mode 11, to confirm that the upper bit alone selects halt. Entry pulses sent during standby and settle show whether requests are blocked outside run, and random pin values show whether the pin freeze is exact.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

   typedef enum logic [2:0] {
      ST_RUN    = 3'd0,
      ST_IDLE   = 3'd1,
      ST_STBY   = 3'd2,
      ST_HALT   = 3'd3,
      ST_SETTLE = 3'd4
   } lpm_state_e;

   localparam logic [1:0] CFG_MODE = 2'd0;
   localparam logic [1:0] CFG_MASK = 2'd1;
   localparam logic [1:0] CFG_QUAL = 2'd2;

   // upper selector bit alone picks halt
   function automatic lpm_state_e target_state(input logic [1:0] sel);
      if (sel[1])      return ST_HALT;
      else if (sel[0]) return ST_STBY;
      else             return ST_IDLE;
   endfunction

endpackage

// File: rtl/lpm_regs.sv
module lpm_regs #(
   parameter int GPIO_W = 32,
   parameter int QUAL_W = 6,
   parameter int DATA_W = 32,
   parameter int ADDR_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [1:0]        mode_o,
   output logic [GPIO_W-1:0] mask_o,
   output logic [QUAL_W-1:0] qual_o
);
   import lpm_pkg::*;

   generate
      if (GPIO_W > DATA_W) begin : g_bad_mask
         $error("lpm_regs: GPIO_W must not exceed DATA_W");
      end
      if (QUAL_W < 1 || QUAL_W >= DATA_W) begin : g_bad_qual
         $error("lpm_regs: QUAL_W out of range");
      end
      if (ADDR_W < 2) begin : g_bad_addr
         $error("lpm_regs: ADDR_W must be at least 2");
      end
   endgenerate

   logic hit_mode, hit_mask, hit_qual;

   always_comb begin
      hit_mode = we && (addr == ADDR_W'(CFG_MODE));
      hit_mask = we && (addr == ADDR_W'(CFG_MASK));
      hit_qual = we && (addr == ADDR_W'(CFG_QUAL));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_o <= '0;
         mask_o <= '0;
         qual_o <= '0;
      end else begin
         if (hit_mode) mode_o <= wdata[1:0];
         if (hit_mask) mask_o <= wdata[GPIO_W-1:0];
         if (hit_qual) qual_o <= wdata[QUAL_W-1:0];
      end
   end

endmodule

// File: rtl/lpm_wake_qual.sv
module lpm_wake_qual #(
   parameter int GPIO_W = 32,
   parameter int QUAL_W = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [GPIO_W-1:0] gpio_n,
   input  logic [GPIO_W-1:0] mask,
   input  logic [QUAL_W-1:0] qual,
   input  logic              active,
   output logic              sel_low_o,
   output logic              qualified_o
);
   localparam int CNT_W = QUAL_W + 1;

   logic [GPIO_W-1:0] line_hit;
   logic [CNT_W-1:0]  cnt_q;
   logic [CNT_W-1:0]  reload;

   generate
      for (genvar g = 0; g < GPIO_W; g++) begin : g_line
         assign line_hit[g] = mask[g] & ~gpio_n[g];
      end
   endgenerate

   assign sel_low_o = |line_hit;
   assign reload    = {1'b0, qual} + CNT_W'(1);

   // down-counter: reload whenever not counting a continuous low
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (!active || !sel_low_o) begin
         cnt_q <= reload;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - CNT_W'(1);
      end
   end

   assign qualified_o = active && sel_low_o && (cnt_q == '0);

endmodule

// File: rtl/lpm_fsm.sv
module lpm_fsm #(
   parameter int SETTLE_CYC = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                idle_req,
   input  logic [1:0]          mode,
   input  logic                wdclk_active,
   input  logic                wd_int_n,
   input  logic                irq_pend,
   input  logic                dbg_req,
   input  logic                gpio_hit,
   input  logic                gpio_qual,
   output lpm_pkg::lpm_state_e state_o,
   output logic                wake_o,
   output logic                osc_en_o,
   output logic                core_en_o,
   output logic                sys_en_o
);
   import lpm_pkg::*;

   localparam int SET_W = (SETTLE_CYC > 1) ? $clog2(SETTLE_CYC) : 1;

   generate
      if (SETTLE_CYC < 1) begin : g_bad_settle
         $error("lpm_fsm: SETTLE_CYC must be at least 1");
      end
   endgenerate

   lpm_state_e state_q, state_d;
   logic [SET_W-1:0] settle_q, settle_d;
   logic wake_d;
   logic wd_wake;

   assign wd_wake = !wd_int_n;

   always_comb begin
      state_d  = state_q;
      settle_d = settle_q;
      wake_d   = 1'b0;
      unique case (state_q)
         ST_RUN: begin
            if (idle_req) begin
               if (target_state(mode) != ST_HALT || wdclk_active)
                  state_d = target_state(mode);
            end
         end
         ST_IDLE: begin
            if (wd_wake || irq_pend) begin
               state_d = ST_RUN;
               wake_d  = 1'b1;
            end
         end
         ST_STBY: begin
            if (wd_wake || dbg_req || gpio_qual) begin
               state_d = ST_RUN;
               wake_d  = 1'b1;
            end
         end
         ST_HALT: begin
            if (wd_wake || dbg_req || gpio_hit) begin
               state_d  = ST_SETTLE;
               settle_d = SET_W'(SETTLE_CYC - 1);
            end
         end
         ST_SETTLE: begin
            if (settle_q == '0) begin
               state_d = ST_RUN;
               wake_d  = 1'b1;
            end else begin
               settle_d = settle_q - SET_W'(1);
            end
         end
         default: state_d = ST_RUN;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_RUN;
         settle_q <= '0;
         wake_o   <= 1'b0;
      end else begin
         state_q  <= state_d;
         settle_q <= settle_d;
         wake_o   <= wake_d;
      end
   end

   always_comb begin
      osc_en_o  = (state_q != ST_HALT);
      core_en_o = (state_q == ST_RUN) || (state_q == ST_IDLE);
      sys_en_o  = (state_q == ST_RUN) || (state_q == ST_IDLE);
   end

   assign state_o = state_q;

endmodule

// File: rtl/lpm_pin_hold.sv
module lpm_pin_hold #(
   parameter int PIN_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [PIN_W-1:0] pin_i,
   output logic [PIN_W-1:0] pin_o
);
   generate
      if (PIN_W < 1) begin : g_bad_pin
         $error("lpm_pin_hold: PIN_W must be at least 1");
      end
      for (genvar p = 0; p < PIN_W; p++) begin : g_bit
         logic held_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   held_q <= 1'b0;
            else if (run) held_q <= pin_i[p];
         end
         assign pin_o[p] = run ? pin_i[p] : held_q;
      end
   endgenerate

endmodule

// File: rtl/lpm_sequencer.sv
module lpm_sequencer #(
   parameter int GPIO_W     = 32,
   parameter int QUAL_W     = 6,
   parameter int DATA_W     = 32,
   parameter int ADDR_W     = 2,
   parameter int PIN_W      = 8,
   parameter int SETTLE_CYC = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [ADDR_W-1:0] cfg_addr,
   input  logic [DATA_W-1:0] cfg_wdata,
   input  logic              idle_req,
   input  logic              wdclk_active,
   input  logic              wd_int_n,
   input  logic              irq_pend,
   input  logic              dbg_req,
   input  logic [GPIO_W-1:0] gpio_n,
   input  logic [PIN_W-1:0]  pin_i,
   output logic [PIN_W-1:0]  pin_o,
   output logic              osc_pll_en,
   output logic              core_clk_en,
   output logic              sysout_en,
   output logic              wake_o
);
   import lpm_pkg::*;

   logic [1:0]        mode_q;
   logic [GPIO_W-1:0] mask_q;
   logic [QUAL_W-1:0] qual_q;
   logic              gpio_hit, gpio_qual;
   lpm_state_e        state_q;

   lpm_regs #(
      .GPIO_W(GPIO_W), .QUAL_W(QUAL_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
      .mode_o(mode_q), .mask_o(mask_q), .qual_o(qual_q)
   );

   lpm_wake_qual #(
      .GPIO_W(GPIO_W), .QUAL_W(QUAL_W)
   ) u_qual (
      .clk(clk), .rst_n(rst_n), .gpio_n(gpio_n), .mask(mask_q), .qual(qual_q),
      .active(state_q == ST_STBY), .sel_low_o(gpio_hit), .qualified_o(gpio_qual)
   );

   lpm_fsm #(
      .SETTLE_CYC(SETTLE_CYC)
   ) u_fsm (
      .clk(clk), .rst_n(rst_n), .idle_req(idle_req), .mode(mode_q),
      .wdclk_active(wdclk_active), .wd_int_n(wd_int_n), .irq_pend(irq_pend),
      .dbg_req(dbg_req), .gpio_hit(gpio_hit), .gpio_qual(gpio_qual),
      .state_o(state_q), .wake_o(wake_o), .osc_en_o(osc_pll_en),
      .core_en_o(core_clk_en), .sys_en_o(sysout_en)
   );

   lpm_pin_hold #(
      .PIN_W(PIN_W)
   ) u_pins (
      .clk(clk), .rst_n(rst_n), .run(state_q == ST_RUN), .pin_i(pin_i), .pin_o(pin_o)
   );

endmodule

// File: rtl/lpm_sequencer_chk.sv
module lpm_sequencer_chk #(
   parameter int PIN_W = 8
) (
   input logic                clk,
   input logic                rst_n,
   input logic                idle_req,
   input logic [1:0]          mode_q,
   input logic                wdclk_active,
   input lpm_pkg::lpm_state_e state_q,
   input logic                osc_pll_en,
   input logic                core_clk_en,
   input logic [PIN_W-1:0]    pin_o,
   input logic                wake_o
);
   import lpm_pkg::*;

   a_r7_halt_refused: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_RUN && idle_req && mode_q[1] && !wdclk_active) |=> (state_q == ST_RUN));

   a_r8_settle_before_core: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(osc_pll_en) |-> !core_clk_en);

   a_r9_wake_single: assert property (@(posedge clk) disable iff (!rst_n)
      wake_o |=> !wake_o);

   a_r9_wake_in_run: assert property (@(posedge clk) disable iff (!rst_n)
      wake_o |-> core_clk_en);

   a_r11_pins_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q != ST_RUN && $past(state_q) != ST_RUN) |-> $stable(pin_o));

   a_r10_no_reentry: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_SETTLE) |=> (state_q == ST_SETTLE || state_q == ST_RUN));

endmodule

bind lpm_sequencer lpm_sequencer_chk #(.PIN_W(PIN_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .idle_req(idle_req), .mode_q(mode_q),
   .wdclk_active(wdclk_active), .state_q(state_q), .osc_pll_en(osc_pll_en),
   .core_clk_en(core_clk_en), .pin_o(pin_o), .wake_o(wake_o)
);

// File: tb/lpm_sequencer_tb_top.sv
module lpm_sequencer_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [1:0]  cfg_addr = '0;
   logic [31:0] cfg_wdata = '0;
   logic        idle_req = 1'b0;
   logic        wdclk_active = 1'b1;
   logic        wd_int_n = 1'b1;
   logic        irq_pend = 1'b0;
   logic        dbg_req = 1'b0;
   logic [31:0] gpio_n = '1;
   logic [7:0]  pin_i = '0;
   logic [7:0]  pin_o;
   logic        osc_pll_en, core_clk_en, sysout_en, wake_o;

   always #2.5 clk = ~clk;

   lpm_sequencer dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .idle_req(idle_req), .wdclk_active(wdclk_active),
      .wd_int_n(wd_int_n), .irq_pend(irq_pend), .dbg_req(dbg_req),
      .gpio_n(gpio_n), .pin_i(pin_i), .pin_o(pin_o), .osc_pll_en(osc_pll_en),
      .core_clk_en(core_clk_en), .sysout_en(sysout_en), .wake_o(wake_o)
   );

   int checks = 0;
   int failures = 0;
   bit done = 0;
   string tag = "R1";

   // behavioural reference: 0 run, 1 idle, 2 standby, 3 halt, 4 settle
   int          m_st = 0;
   int          m_qc = 0;
   int          m_sc = 0;
   int          m_mode = 0;
   int          m_qual = 0;
   bit [31:0]   m_mask = '0;
   bit          m_wake = 0;
   bit [7:0]    m_hold = '0;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_st = 0; m_qc = 0; m_sc = 0; m_mode = 0; m_qual = 0;
         m_mask = '0; m_wake = 0; m_hold = '0;
      end else begin
         bit low;
         low = ((~gpio_n) & m_mask) != 0;
         m_wake = 0;
         case (m_st)
            0: begin
               m_hold = pin_i;
               if (idle_req) begin
                  if (m_mode == 0) m_st = 1;
                  else if (m_mode == 1) m_st = 2;
                  else if (wdclk_active) m_st = 3;
               end
            end
            1: if (!wd_int_n || irq_pend) begin m_st = 0; m_wake = 1; end
            2: begin
               if (!wd_int_n || dbg_req) begin m_st = 0; m_wake = 1; end
               else if (low) begin
                  if (m_qc == 0) begin m_st = 0; m_wake = 1; end
                  else m_qc--;
               end
            end
            3: if (low || dbg_req || !wd_int_n) begin m_st = 4; m_sc = 15; end
            default: begin
               if (m_sc == 0) begin m_st = 0; m_wake = 1; end
               else m_sc--;
            end
         endcase
         if (m_st != 2) m_qc = m_qual + 1;
         else if (!low) m_qc = m_qual + 1;
         if (cfg_we) begin
            if (cfg_addr == 0) m_mode = int'(cfg_wdata[1:0]);
            if (cfg_addr == 1) m_mask = cfg_wdata;
            if (cfg_addr == 2) m_qual = int'(cfg_wdata[5:0]);
         end
      end
   end

   task automatic check1(string req, string what, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s actual=%0h expected=%0h t=%0t", req, what, act, exp, $time);
      end
   endtask

   task automatic compare_all();
      bit e_osc, e_core;
      e_osc  = (m_st != 3);
      e_core = (m_st == 0 || m_st == 1);
      check1(tag, "osc_pll_en", 32'(osc_pll_en), 32'(e_osc));
      check1(tag, "core_clk_en", 32'(core_clk_en), 32'(e_core));
      check1(tag, "sysout_en", 32'(sysout_en), 32'(e_core));
      check1((m_wake ? "R9" : tag), "wake_o", 32'(wake_o), 32'(m_wake));
      check1("R11", "pin_o", 32'(pin_o), 32'(m_st == 0 ? pin_i : m_hold));
   endtask

   task automatic cyc(int n = 1);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         compare_all();
         pin_i = 8'($urandom);
      end
   endtask

   task automatic wr(logic [1:0] a, logic [31:0] d);
      cfg_we = 1; cfg_addr = a; cfg_wdata = d;
      cyc();
      cfg_we = 0;
   endtask

   task automatic enter();
      idle_req = 1;
      cyc();
      idle_req = 0;
   endtask

   task automatic summary();
      if (!done) begin
         done = 1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   endtask

   int wd_cnt = 0;
   always @(posedge clk) begin
      wd_cnt++;
      if (wd_cnt > 100000) begin
         failures++;
         checks++;
         $display("FAIL watchdog expired");
         summary();
      end
   end

   initial begin
      // R1: reset state
      #1;
      tag = "R1";
      compare_all();
      check1("R1", "core_clk_en in reset", 32'(core_clk_en), 32'd1);
      cyc(3);
      rst_n = 1;
      cyc(2);
      check1("R1", "wake_o after reset", 32'(wake_o), 32'd0);

      // R3: idle, mode 00, wake by interrupt and watchdog
      tag = "R3";
      wr(2'd0, 32'h0);
      enter();
      cyc(4);
      check1("R3", "idle core_clk_en", 32'(core_clk_en), 32'd1);
      dbg_req = 1; cyc(2); dbg_req = 0;   // not a wake source in idle
      irq_pend = 1; cyc(); irq_pend = 0;
      cyc(2);
      enter(); cyc(3);
      wd_int_n = 0; cyc(); wd_int_n = 1;
      cyc(2);

      // R2, R4, R5: standby with qualification count 3
      tag = "R5";
      wr(2'd0, 32'h1);
      wr(2'd1, 32'h0000_0010);
      wr(2'd2, 32'h3);
      enter();
      cyc(2);
      check1("R4", "standby core_clk_en", 32'(core_clk_en), 32'd0);
      check1("R4", "standby osc_pll_en", 32'(osc_pll_en), 32'd1);
      gpio_n[4] = 0; cyc(4); gpio_n[4] = 1;   // one short of 5
      cyc(2);
      check1("R5", "short pulse ignored", 32'(core_clk_en), 32'd0);
      gpio_n[7] = 0; cyc(10); gpio_n[7] = 1;  // unmasked line
      check1("R5", "unmasked line ignored", 32'(core_clk_en), 32'd0);
      irq_pend = 1; cyc(2); irq_pend = 0;      // not a standby source
      tag = "R10";
      enter(); cyc(2);                          // ignored while in standby
      tag = "R5";
      gpio_n[4] = 0; cyc(5); gpio_n[4] = 1;   // exactly 5 samples
      cyc(2);
      check1("R5", "qualified wake to run", 32'(core_clk_en), 32'd1);
      tag = "R4";
      enter(); cyc(3);
      dbg_req = 1; cyc(); dbg_req = 0;
      cyc(2);
      enter(); cyc(2);
      wd_int_n = 0; cyc(); wd_int_n = 1;
      cyc(2);

      // R7: halt refused without watchdog clock
      tag = "R7";
      wr(2'd0, 32'h2);
      wdclk_active = 0;
      enter(); cyc(3);
      check1("R7", "halt refused", 32'(osc_pll_en), 32'd1);
      wdclk_active = 1;

      // R6, R8: halt, mode 11, GPIO wake and settle
      tag = "R6";
      wr(2'd0, 32'h3);
      enter(); cyc(3);
      check1("R6", "halt osc_pll_en", 32'(osc_pll_en), 32'd0);
      irq_pend = 1; cyc(3); irq_pend = 0;
      check1("R6", "irq ignored in halt", 32'(osc_pll_en), 32'd0);
      tag = "R8";
      gpio_n[4] = 0; cyc(); gpio_n[4] = 1;
      tag = "R10";
      enter();
      tag = "R8";
      cyc(14);
      check1("R8", "still settling", 32'(core_clk_en), 32'd0);
      cyc(4);
      check1("R8", "back to run", 32'(core_clk_en), 32'd1);

      // halt woken by debugger, then by watchdog
      tag = "R6";
      enter(); cyc(2);
      dbg_req = 1; cyc(); dbg_req = 0;
      cyc(20);
      enter(); cyc(2);
      wd_int_n = 0; cyc(); wd_int_n = 1;
      cyc(20);
      check1("R9", "run after watchdog halt wake", 32'(core_clk_en), 32'd1);

      summary();
   end

endmodule